// File: doc/BRIEF.md
# Port Access Decoder with Mailbox

This block sits behind one port of a pair of clocked FIFOs that carry data in opposite directions over a shared bidirectional data bus. Four control inputs, an active-low port select, a direction bit (high for a write into the chip), an access enable and a mailbox select, decide what the next rising clock edge does. The options are a push into the outgoing FIFO, a pop from the incoming FIFO, a load of the outgoing mailbox register or a fetch from the incoming mailbox register. The bus pads are modelled as an output-enable signal and a data output. The output either shows the incoming FIFO's head register or the incoming mailbox register.

The two mailbox registers let small messages travel outside the FIFO queues. Each has a vacancy flag: high means empty, low means a message is waiting. The outgoing mailbox is emptied by a read strobe from the other port. The incoming mailbox is filled by a write strobe from the other port. FIFO storage and the other port's logic are outside this block; only the mailbox handshake strobes cross the boundary.

Top module: `portdec_port`

## Requirements
- R1: `bus_oe` is high in the same cycle exactly when `sel_n` is 0 and `dir_wr` is 0, whatever the other inputs.
- R2: While `bus_oe` is high, `bus_out` equals the incoming mailbox register when `mail_sel` is 1 and `fifo_head` when `mail_sel` is 0, whatever the level of `acc_en`.
- R3: `fifo_push` is high in the same cycle exactly when `sel_n`=0, `dir_wr`=1, `acc_en`=1, `mail_sel`=0 and `push_room`=1.
- R4: `fifo_pop` is high in the same cycle exactly when `sel_n`=0, `dir_wr`=0, `acc_en`=1, `mail_sel`=0 and `pop_avail`=1.
- R5: A mailbox load (`sel_n`=0, `dir_wr`=1, `acc_en`=1, `mail_sel`=1) at a rising edge while `tx_mail_vacant` is 1 stores `bus_in` into `tx_mail_data` and drives `tx_mail_vacant` to 0 after that edge. While `tx_mail_vacant` is 0 the load is ignored and `tx_mail_data` keeps its value.
- R6: `peer_tx_take` at a rising edge sets `tx_mail_vacant` to 1 after that edge and leaves `tx_mail_data` unchanged.
- R7: A mailbox fetch (`sel_n`=0, `dir_wr`=0, `acc_en`=1, `mail_sel`=1) at a rising edge sets `rx_mail_vacant` to 1. `peer_rx_put` alone stores `peer_rx_data` in the incoming register and drives `rx_mail_vacant` to 0, even over an unread message. If both happen at the same edge, the fetch wins: the flag ends at 1 and the register keeps its old value.
- R8: With `sel_n`=1 or `acc_en`=0, no FIFO strobe rises and no local mailbox load or fetch takes effect.
- R9: A synchronous reset (`rst`=1 at a rising edge) sets both vacancy flags to 1 and both mailbox registers to zero.
- R10: With `mail_sel`=1 neither FIFO strobe asserts, and mailbox accesses do not depend on `push_room` or `pop_avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Port select, active low |
| dir_wr | input | 1 | 1 = bus writes into the chip, 0 = bus reads from it |
| acc_en | input | 1 | Access enable for the coming edge |
| mail_sel | input | 1 | 1 = mailbox access, 0 = FIFO access |
| bus_in | input | W | Data arriving from the bus pads |
| bus_out | output | W | Data sent to the bus pads |
| bus_oe | output | 1 | Pad output enable |
| push_room | input | 1 | Outgoing FIFO can accept a word |
| pop_avail | input | 1 | Incoming FIFO head register holds a word |
| fifo_push | output | 1 | Push strobe for the outgoing FIFO |
| fifo_pop | output | 1 | Pop strobe for the incoming FIFO |
| fifo_head | input | W | Incoming FIFO head register |
| tx_mail_data | output | W | Outgoing mailbox register, read by the other port |
| tx_mail_vacant | output | 1 | 1 = outgoing mailbox empty |
| peer_tx_take | input | 1 | Other port reads the outgoing mailbox |
| rx_mail_vacant | output | 1 | 1 = incoming mailbox empty |
| peer_rx_put | input | 1 | Other port writes the incoming mailbox |
| peer_rx_data | input | W | Data written by the other port |

## Verification
The bus enable, the bus data selection and both FIFO strobes are combinational, so they are due in the same cycle as the control inputs. The bench compares them a short delay after it drives new inputs on the falling edge. The mailbox registers and vacancy flags change one rising edge after the access. The bench updates its own model of them right after that edge and compares at the following falling edge. Nothing is sampled at an active edge.

// File: rtl/portdec_pkg.sv
package portdec_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE       = 3'd0,
        ACC_FIFO_PUSH  = 3'd1,
        ACC_FIFO_POP   = 3'd2,
        ACC_MAIL_LOAD  = 3'd3,
        ACC_MAIL_FETCH = 3'd4
    } acc_op_e;

    typedef struct packed {
        logic sel_n;
        logic write;
        logic enable;
        logic mail;
    } acc_ctl_t;

    typedef struct packed {
        acc_op_e op;
        logic    drive;
        logic    pick_mail;
    } acc_dec_t;

    function automatic acc_dec_t decode_access(acc_ctl_t c, logic room, logic avail);
        acc_dec_t d;
        d.drive     = !c.sel_n && !c.write;
        d.pick_mail = c.mail;
        d.op        = ACC_IDLE;
        if (!c.sel_n && c.enable) begin
            if (c.write) begin
                if (c.mail)      d.op = ACC_MAIL_LOAD;
                else if (room)   d.op = ACC_FIFO_PUSH;
            end else begin
                if (c.mail)      d.op = ACC_MAIL_FETCH;
                else if (avail)  d.op = ACC_FIFO_POP;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/portdec_decode.sv
module portdec_decode
    import portdec_pkg::*;
(
    input  logic     sel_n,
    input  logic     dir_wr,
    input  logic     acc_en,
    input  logic     mail_sel,
    input  logic     push_room,
    input  logic     pop_avail,
    output acc_dec_t dec
);
    acc_ctl_t ctl;

    always_comb begin
        ctl.sel_n  = sel_n;
        ctl.write  = dir_wr;
        ctl.enable = acc_en;
        ctl.mail   = mail_sel;
        dec        = decode_access(ctl, push_room, pop_avail);
    end
endmodule

// File: rtl/portdec_mail_slot.sv
module portdec_mail_slot #(
    parameter int W            = 36,
    parameter bit LOAD_GUARDED = 1'b1,
    parameter bit DRAIN_WINS   = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         drain,
    output logic [W-1:0] data_q,
    output logic         vacant_q
);
    logic load_ok;

    generate
        if (LOAD_GUARDED) begin : g_guard
            assign load_ok = load && vacant_q;
        end else begin : g_open
            assign load_ok = load;
        end
    endgenerate

    generate
        if (DRAIN_WINS) begin : g_drain_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q   <= '0;
                    vacant_q <= 1'b1;
                end else if (drain) begin
                    vacant_q <= 1'b1;
                end else if (load_ok) begin
                    data_q   <= load_data;
                    vacant_q <= 1'b0;
                end
            end
        end else begin : g_load_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q   <= '0;
                    vacant_q <= 1'b1;
                end else if (load_ok) begin
                    data_q   <= load_data;
                    vacant_q <= 1'b0;
                end else if (drain) begin
                    vacant_q <= 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/portdec_bus_mux.sv
module portdec_bus_mux #(
    parameter int W = 36
) (
    input  logic         pick_mail,
    input  logic [W-1:0] mail_word,
    input  logic [W-1:0] fifo_word,
    output logic [W-1:0] bus_word
);
    always_comb begin
        bus_word = pick_mail ? mail_word : fifo_word;
    end
endmodule

// File: rtl/portdec_port.sv
module portdec_port
    import portdec_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic         dir_wr,
    input  logic         acc_en,
    input  logic         mail_sel,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    input  logic         push_room,
    input  logic         pop_avail,
    output logic         fifo_push,
    output logic         fifo_pop,
    input  logic [W-1:0] fifo_head,
    output logic [W-1:0] tx_mail_data,
    output logic         tx_mail_vacant,
    input  logic         peer_tx_take,
    output logic         rx_mail_vacant,
    input  logic         peer_rx_put,
    input  logic [W-1:0] peer_rx_data
);
    acc_dec_t     dec;
    logic [W-1:0] rx_mail_q;
    logic         local_load;
    logic         local_fetch;

    portdec_decode u_dec (
        .sel_n     (sel_n),
        .dir_wr    (dir_wr),
        .acc_en    (acc_en),
        .mail_sel  (mail_sel),
        .push_room (push_room),
        .pop_avail (pop_avail),
        .dec       (dec)
    );

    assign local_load  = (dec.op == ACC_MAIL_LOAD);
    assign local_fetch = (dec.op == ACC_MAIL_FETCH);
    assign fifo_push   = (dec.op == ACC_FIFO_PUSH);
    assign fifo_pop    = (dec.op == ACC_FIFO_POP);
    assign bus_oe      = dec.drive;

    portdec_mail_slot #(
        .W            (W),
        .LOAD_GUARDED (1'b1),
        .DRAIN_WINS   (1'b0)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (local_load),
        .load_data (bus_in),
        .drain     (peer_tx_take),
        .data_q    (tx_mail_data),
        .vacant_q  (tx_mail_vacant)
    );

    portdec_mail_slot #(
        .W            (W),
        .LOAD_GUARDED (1'b0),
        .DRAIN_WINS   (1'b1)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .load      (peer_rx_put),
        .load_data (peer_rx_data),
        .drain     (local_fetch),
        .data_q    (rx_mail_q),
        .vacant_q  (rx_mail_vacant)
    );

    portdec_bus_mux #(.W(W)) u_mux (
        .pick_mail (dec.pick_mail),
        .mail_word (rx_mail_q),
        .fifo_word (fifo_head),
        .bus_word  (bus_out)
    );
endmodule

// File: rtl/portdec_checker.sv
module portdec_checker #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst,
    input logic         sel_n,
    input logic         dir_wr,
    input logic         acc_en,
    input logic         mail_sel,
    input logic [W-1:0] bus_in,
    input logic         push_room,
    input logic         pop_avail,
    input logic         fifo_push,
    input logic         fifo_pop,
    input logic [W-1:0] tx_mail_data,
    input logic         tx_mail_vacant,
    input logic         peer_tx_take,
    input logic         rx_mail_vacant,
    input logic         peer_rx_put,
    input logic [W-1:0] peer_rx_data,
    input logic [W-1:0] rx_mail_q
);
    logic load_req;
    logic fetch_req;
    assign load_req  = !sel_n && dir_wr && acc_en && mail_sel;
    assign fetch_req = !sel_n && !dir_wr && acc_en && mail_sel;

    assert_push_gate_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> (push_room && !sel_n && dir_wr && acc_en && !mail_sel));

    assert_pop_gate_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (pop_avail && !sel_n && !dir_wr && acc_en && !mail_sel));

    assert_load_store_R5: assert property (@(posedge clk) disable iff (rst)
        (load_req && tx_mail_vacant) |=> (!tx_mail_vacant && tx_mail_data == $past(bus_in)));

    assert_load_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (!tx_mail_vacant) |=> $stable(tx_mail_data));

    assert_take_frees_R6: assert property (@(posedge clk) disable iff (rst)
        (peer_tx_take && !tx_mail_vacant) |=> tx_mail_vacant);

    assert_fetch_wins_R7: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> (rx_mail_vacant && $stable(rx_mail_q)));

    assert_put_fills_R7: assert property (@(posedge clk) disable iff (rst)
        (peer_rx_put && !fetch_req) |=> (!rx_mail_vacant && rx_mail_q == $past(peer_rx_data)));

    assert_idle_port_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_n || !acc_en) |-> (!fifo_push && !fifo_pop));

    assert_mail_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        mail_sel |-> (!fifo_push && !fifo_pop));
endmodule

bind portdec_port portdec_checker #(.W(W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sel_n          (sel_n),
    .dir_wr         (dir_wr),
    .acc_en         (acc_en),
    .mail_sel       (mail_sel),
    .bus_in         (bus_in),
    .push_room      (push_room),
    .pop_avail      (pop_avail),
    .fifo_push      (fifo_push),
    .fifo_pop       (fifo_pop),
    .tx_mail_data   (tx_mail_data),
    .tx_mail_vacant (tx_mail_vacant),
    .peer_tx_take   (peer_tx_take),
    .rx_mail_vacant (rx_mail_vacant),
    .peer_rx_put    (peer_rx_put),
    .peer_rx_data   (peer_rx_data),
    .rx_mail_q      (rx_mail_q)
);

// File: tb/sim_portdec_port.sv
`timescale 1ns/1ps
module sim_portdec_port;
    localparam int W = 36;
    localparam int NRAND = 3000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_n = 1'b1, dir_wr = 1'b0, acc_en = 1'b0, mail_sel = 1'b0;
    logic [W-1:0] bus_in = '0, fifo_head = '0, peer_rx_data = '0;
    logic         push_room = 1'b0, pop_avail = 1'b0;
    logic         peer_tx_take = 1'b0, peer_rx_put = 1'b0;
    logic [W-1:0] bus_out, tx_mail_data;
    logic         bus_oe, fifo_push, fifo_pop, tx_mail_vacant, rx_mail_vacant;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_tx, m_rx;
    logic         m_txv, m_rxv;

    always #10 clk = ~clk;

    portdec_port #(.W(W)) u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .dir_wr(dir_wr), .acc_en(acc_en),
        .mail_sel(mail_sel), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .push_room(push_room), .pop_avail(pop_avail), .fifo_push(fifo_push),
        .fifo_pop(fifo_pop), .fifo_head(fifo_head), .tx_mail_data(tx_mail_data),
        .tx_mail_vacant(tx_mail_vacant), .peer_tx_take(peer_tx_take),
        .rx_mail_vacant(rx_mail_vacant), .peer_rx_put(peer_rx_put),
        .peer_rx_data(peer_rx_data)
    );

    function automatic bit f_active();
        return !sel_n && acc_en;
    endfunction
    function automatic bit f_push();
        return f_active() && dir_wr && !mail_sel && push_room;
    endfunction
    function automatic bit f_pop();
        return f_active() && !dir_wr && !mail_sel && pop_avail;
    endfunction
    function automatic bit f_load();
        return f_active() && dir_wr && mail_sel;
    endfunction
    function automatic bit f_fetch();
        return f_active() && !dir_wr && mail_sel;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    task automatic check_now();
        string ftag;
        ftag = mail_sel ? "R10" : ((sel_n || !acc_en) ? "R8" : "R3");
        chk("R1 bus_oe", {63'd0, bus_oe}, {63'd0, (!sel_n && !dir_wr)});
        if (!sel_n && !dir_wr)
            chk("R2 bus_out", {28'd0, bus_out}, {28'd0, (mail_sel ? m_rx : fifo_head)});
        chk({ftag, " fifo_push"}, {63'd0, fifo_push}, {63'd0, f_push()});
        chk({(ftag == "R3") ? "R4" : ftag, " fifo_pop"}, {63'd0, fifo_pop}, {63'd0, f_pop()});
        chk("R5 tx_mail_data", {28'd0, tx_mail_data}, {28'd0, m_tx});
        chk("R6 tx_mail_vacant", {63'd0, tx_mail_vacant}, {63'd0, m_txv});
        chk("R7 rx_mail_vacant", {63'd0, rx_mail_vacant}, {63'd0, m_rxv});
    endtask

    task automatic model_edge();
        bit ld, fe;
        ld = f_load();
        fe = f_fetch();
        if (ld && m_txv) begin
            m_tx  = bus_in;
            m_txv = 1'b0;
        end else if (peer_tx_take) begin
            m_txv = 1'b1;
        end
        if (fe) begin
            m_rxv = 1'b1;
        end else if (peer_rx_put) begin
            m_rx  = peer_rx_data;
            m_rxv = 1'b0;
        end
    endtask

    task automatic step(bit s_n, bit d, bit e, bit m, bit room, bit avail,
                        bit take, bit put, logic [W-1:0] din, logic [W-1:0] pdat);
        @(negedge clk);
        sel_n = s_n; dir_wr = d; acc_en = e; mail_sel = m;
        push_room = room; pop_avail = avail;
        peer_tx_take = take; peer_rx_put = put;
        bus_in = din; peer_rx_data = pdat; fifo_head = rnd_word();
        #2;
        check_now();
        @(posedge clk);
        #1;
        model_edge();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(20240611);
        m_tx = '0; m_rx = '0; m_txv = 1'b1; m_rxv = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sel_n = 1'b0; dir_wr = 1'b0; mail_sel = 1'b1; acc_en = 1'b0;
        #2;
        chk("R9 tx_mail_vacant", {63'd0, tx_mail_vacant}, 64'd1);
        chk("R9 rx_mail_vacant", {63'd0, rx_mail_vacant}, 64'd1);
        chk("R9 tx_mail_data",   {28'd0, tx_mail_data}, 64'd0);
        chk("R9 rx register via bus", {28'd0, bus_out}, 64'd0);

        // R5: load into empty mailbox, then ignored load while full
        step(0,1,1,1,0,0,0,0, 36'h0_A5A5_1234, '0);
        step(0,1,1,1,1,1,0,0, 36'h3_FFFF_0000, '0);
        step(0,0,0,0,0,0,0,0, '0, '0);
        chk("R5 ignored load kept", {28'd0, tx_mail_data}, {28'd0, 36'h0_A5A5_1234});
        // R6: other port takes it, then load allowed again
        step(1,0,0,0,0,0,1,0, '0, '0);
        step(0,1,1,1,0,0,0,0, 36'h1_2345_6789, '0);
        // R7: put alone, read on bus, then put+fetch together
        step(1,0,0,0,0,0,0,1, '0, 36'h7_0000_00C3);
        step(0,0,0,1,0,0,0,0, '0, '0);
        step(0,0,1,1,0,0,0,1, '0, 36'h5_5555_5555);
        step(0,0,0,1,0,0,0,0, '0, '0);
        chk("R7 fetch wins keeps register", {28'd0, bus_out}, {28'd0, 36'h7_0000_00C3});
        // R7: put over unread message overwrites
        step(1,0,0,0,0,0,0,1, '0, 36'h0_0000_0011);
        step(1,0,0,0,0,0,0,1, '0, 36'h0_0000_0022);
        // R8: enable low and deselected port
        step(0,1,0,1,1,1,0,0, 36'h9_9999_9999, '0);
        step(1,0,1,1,1,1,0,0, '0, '0);
        step(1,1,1,0,1,1,0,0, '0, '0);
        chk("R8 no load while idle", {63'd0, tx_mail_vacant}, {63'd0, m_txv});

        for (int i = 0; i < NRAND; i++) begin
            step(($urandom % 5) == 0, $urandom % 2, ($urandom % 10) < 7, ($urandom % 3) == 0,
                 $urandom % 2, $urandom % 2, ($urandom % 5) == 0, ($urandom % 5) == 0,
                 rnd_word(), rnd_word());
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule